// File: doc/BRIEF.md
# Trinomial Word-Serial Field Reducer

This block turns a binary polynomial of degree up to 464, such as the raw product or square of two 233-bit field elements, into its residue modulo x^233 + x^74 + 1. The polynomial is loaded as a 512-bit vector in which bit n is the coefficient of x^n. It is kept as sixteen 32-bit words, where word j holds bits 32j to 32j+31.

After a start pulse the block folds one upper word per clock cycle into the words below it, taking word 15 first and word 8 last. Each fold is a fixed set of four shift-and-XOR updates, one pair for the x^0 image and one pair for the x^74 image of the removed word. One more cycle folds the bits of word 7 that lie at or above x^233 and clears them. A one-cycle done pulse then marks the 233-bit result as valid. The result stays on the output until the next operation is accepted.

Top module: `trinomial_reducer`

## Requirements
- R1: After reset, done is low and result is all zero.
- R2: For any poly_in of degree at most 464 (bit n of poly_in is the coefficient of x^n), result equals poly_in mod (x^233 + x^74 + 1), with bit n of result the coefficient of x^n.
- R3: done is high for exactly one cycle, at the ninth rising edge after the edge that samples start high while idle. result is valid from that cycle.
- R4: While an operation is in progress, start and poly_in are ignored. The running operation keeps its latency and its result, and no second done follows.
- R5: A start presented in the cycle where done is high is accepted, so operations can run back to back.
- R6: Between done and the next accepted start, result holds its value whatever poly_in does.
- R7: An input of degree below 233 comes back unchanged.
- R8: Every single-term input x^n, for n from 0 to 464, reduces correctly. This includes terms whose images straddle a 32-bit word boundary, and terms in words 12 to 15 whose first images land in words 8 to 11 and must be folded again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a reduction of poly_in; honoured only when idle |
| poly_in | input | 512 | Unreduced polynomial, zero above degree 464 |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 233 | Reduced field element |

## Verification
The start edge counts as edge 0. The eight word folds happen on edges 1 to 8, and the cleanup fold and done happen on edge 9. The bench drives inputs on falling edges and counts falling edges from the start edge. It requires done at exactly the ninth, reads result in that same half cycle, and requires done to be low one cycle later. For the busy-start, back-to-back and hold cases the bench keeps this count going across the extra stimulus. Every expected residue comes from a bit-by-bit long division done in the bench.

// File: rtl/trinomial_reducer_pkg.sv
package trinomial_reducer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FOLD = 2'd1,
        PH_TAIL = 2'd2
    } red_phase_e;

endpackage

// File: rtl/trinomial_word_fold.sv
// One upper word is removed and its images at x^0 and x^K are XORed
// into the lower words. The removed word is cleared before the XORs,
// so an image that lands on the cleared slot is kept.
module trinomial_word_fold #(
    parameter int W  = 32,
    parameter int M  = 233,
    parameter int K  = 74,
    parameter int LW = 8,
    parameter int NW = 16,
    parameter int IW = 4
) (
    input  logic [NW-1:0][W-1:0] words_in,
    input  logic [IW-1:0]        idx,
    output logic [NW-1:0][W-1:0] words_out
);
    // Image at x^0: distance M equals LW words minus SH_LO bits.
    localparam int SH_LO  = LW * W - M;
    // Image at x^K: distance M-K equals OFF_TP words minus SH_TP bits.
    localparam int DIST_TP = M - K;
    localparam int OFF_TP  = (DIST_TP + W - 1) / W;
    localparam int SH_TP   = OFF_TP * W - DIST_TP;

    logic [W-1:0]  t_word;
    logic [IW-1:0] i_lo, i_lo_up, i_tp, i_tp_up;

    always_comb begin
        t_word  = words_in[idx];
        i_lo    = idx - IW'(LW);
        i_lo_up = idx - IW'(LW - 1);
        i_tp    = idx - IW'(OFF_TP);
        i_tp_up = idx - IW'(OFF_TP - 1);

        words_out          = words_in;
        words_out[idx]     = '0;
        words_out[i_lo]    = words_out[i_lo]    ^ (t_word << SH_LO);
        words_out[i_lo_up] = words_out[i_lo_up] ^ (t_word >> (W - SH_LO));
        words_out[i_tp]    = words_out[i_tp]    ^ (t_word << SH_TP);
        words_out[i_tp_up] = words_out[i_tp_up] ^ (t_word >> (W - SH_TP));
    end

endmodule

// File: rtl/trinomial_tail_fold.sv
// Folds the bits of the top low word that lie at x^M and above, then
// clears them with a mask.
module trinomial_tail_fold #(
    parameter int W  = 32,
    parameter int M  = 233,
    parameter int K  = 74,
    parameter int LW = 8
) (
    input  logic [LW-1:0][W-1:0] words_in,
    output logic [LW-1:0][W-1:0] words_out
);
    localparam int TOP_BITS = M - (LW - 1) * W;
    localparam int K_WORD   = K / W;
    localparam int K_SHIFT  = K % W;
    localparam logic [W-1:0] TOP_MASK = W'((64'd1 << TOP_BITS) - 64'd1);

    logic [W-1:0] excess;

    always_comb begin
        excess                = words_in[LW-1] >> TOP_BITS;
        words_out             = words_in;
        words_out[0]          = words_out[0] ^ excess;
        words_out[K_WORD]     = words_out[K_WORD] ^ (excess << K_SHIFT);
        words_out[K_WORD + 1] = words_out[K_WORD + 1] ^ (excess >> (W - K_SHIFT));
        words_out[LW-1]       = words_out[LW-1] & TOP_MASK;
    end

endmodule

// File: rtl/trinomial_reducer.sv
module trinomial_reducer
    import trinomial_reducer_pkg::*;
#(
    parameter int W  = 32,
    parameter int M  = 233,
    parameter int K  = 74,
    localparam int LW = (M + W - 1) / W,
    localparam int NW = 2 * LW,
    localparam int IW = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NW*W-1:0]   poly_in,
    output logic              done,
    output logic [M-1:0]      result
);

    typedef struct packed {
        red_phase_e          phase;
        logic [IW-1:0]       idx;
        logic [NW-1:0][W-1:0] words;
        logic                done;
    } red_state_t;

    red_state_t st_d, st_q;

    logic [NW-1:0][W-1:0] fold_out_d;
    logic [LW-1:0][W-1:0] tail_out_d;

    trinomial_word_fold #(
        .W (W), .M (M), .K (K), .LW (LW), .NW (NW), .IW (IW)
    ) u_fold (
        .words_in  (st_q.words),
        .idx       (st_q.idx),
        .words_out (fold_out_d)
    );

    trinomial_tail_fold #(
        .W (W), .M (M), .K (K), .LW (LW)
    ) u_tail (
        .words_in  (st_q.words[LW-1:0]),
        .words_out (tail_out_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.words = poly_in;
                    st_d.idx   = IW'(NW - 1);
                    st_d.phase = PH_FOLD;
                end
            end
            PH_FOLD: begin
                st_d.words = fold_out_d;
                if (st_q.idx == IW'(LW)) begin
                    st_d.phase = PH_TAIL;
                end else begin
                    st_d.idx = st_q.idx - 1'b1;
                end
            end
            PH_TAIL: begin
                st_d.words[LW-1:0] = tail_out_d;
                st_d.phase         = PH_IDLE;
                st_d.done          = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done   = st_q.done;
    assign result = M'(st_q.words[LW-1:0]);

    // R3: done never lasts longer than a single cycle
    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done only follows the cleanup cycle
    a_r3_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q.phase) == PH_TAIL);

    // R8: every upper word is empty once the descending folds are finished
    a_r8_high_words_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TAIL) |-> (st_q.words[NW-1:LW] == '0));

    // R4: a busy fold step always advances to the next lower word, start or not
    a_r4_fold_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FOLD && st_q.idx != IW'(LW)) |=>
            (st_q.phase == PH_FOLD && st_q.idx == IW'($past(st_q.idx) - 1'b1)));

    // R4: the fold index stays within the upper half while busy
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FOLD) |-> (st_q.idx >= IW'(LW)));

    // R6: an idle block without start keeps its result
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start) |=> $stable(result));

endmodule

// File: tb/trinomial_reducer_tb.sv
module trinomial_reducer_tb;

    localparam int  W        = 32;
    localparam int  M        = 233;
    localparam int  K        = 74;
    localparam int  NB       = 512;
    localparam int  MAXDEG   = 464;
    localparam int  LATENCY  = 9;
    localparam time CLK_PER  = 10ns;
    localparam int  WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] poly_in = '0;
    logic          done;
    logic [M-1:0]  result;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    trinomial_reducer #(.W(W), .M(M), .K(K)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .poly_in (poly_in),
        .done    (done),
        .result  (result)
    );

    always #(CLK_PER / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1'b1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=%0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [M-1:0] ref_mod(input logic [NB-1:0] a);
        logic [NB-1:0] c;
        c = a;
        for (int p = NB - 1; p >= M; p--) begin
            if (c[p]) begin
                c[p]         = 1'b0;
                c[p - M]     = c[p - M] ^ 1'b1;
                c[p - M + K] = c[p - M + K] ^ 1'b1;
            end
        end
        return c[M-1:0];
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rand_poly(output logic [NB-1:0] v);
        for (int j = 0; j < NB / 32; j++) begin
            rng = next_rng(rng);
            v[j*32 +: 32] = rng;
        end
        v = v & ({NB{1'b1}} >> (NB - 1 - MAXDEG));
    endtask

    // Called at a falling edge; the next rising edge samples start.
    task automatic issue(input logic [NB-1:0] v);
        start   = 1'b1;
        poly_in = v;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // Counts falling edges after the start edge until done is seen.
    task automatic wait_done(output int lat);
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic run_check(input logic [NB-1:0] v, input string req);
        int lat;
        logic [M-1:0] exp;
        exp = ref_mod(v);
        issue(v);
        wait_done(lat);
        chk(lat == LATENCY, {req, " latency"}, M'(lat), M'(LATENCY));
        chk(result === exp, req, result, exp);
        @(negedge clk);
        chk(done == 1'b0, "R3 done pulse width", M'(done), '0);
    endtask

    initial begin
        logic [NB-1:0] va, vb;
        logic [M-1:0]  ea, held;
        int lat;
        bit stable_ok;
        bit extra_done;

        repeat (3) @(negedge clk);
        // R1: reset values
        chk(done == 1'b0, "R1 done at reset", M'(done), '0);
        chk(result == '0, "R1 result at reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && result == '0, "R1 idle after reset", result, '0);

        // R8: every single-term input x^n
        for (int n = 0; n <= MAXDEG; n++) begin
            va = '0;
            va[n] = 1'b1;
            run_check(va, "R8 single term");
        end

        // R7: inputs already reduced come back unchanged
        for (int r = 0; r < 8; r++) begin
            rand_poly(va);
            va = va & ({NB{1'b1}} >> (NB - M));
            run_check(va, "R7 reduced input");
            chk(result == va[M-1:0], "R7 unchanged", result, va[M-1:0]);
        end

        // R2: dense patterns, all ones, and pseudo-random inputs
        va = {NB{1'b1}} >> (NB - 1 - MAXDEG);
        run_check(va, "R2 all ones");
        va = '0;
        for (int j = 0; j < NB / 32; j++) va[j*32 +: 32] = 32'hAAAA_5555;
        va = va & ({NB{1'b1}} >> (NB - 1 - MAXDEG));
        run_check(va, "R2 alternating");
        for (int r = 0; r < 200; r++) begin
            rand_poly(va);
            run_check(va, "R2 random");
        end

        // R4: start held with another operand while busy
        rand_poly(va);
        rand_poly(vb);
        ea = ref_mod(va);
        start   = 1'b1;
        poly_in = va;
        @(negedge clk);
        poly_in = vb;
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 3) start = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
        chk(lat == LATENCY, "R4 latency under busy start", M'(lat), M'(LATENCY));
        chk(result === ea, "R4 result of first operand", result, ea);
        extra_done = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) extra_done = 1'b1;
        end
        chk(!extra_done, "R4 no second done", M'(extra_done), '0);
        chk(result === ea, "R4 result kept", result, ea);

        // R6: result holds while poly_in moves and start is low
        held = result;
        stable_ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            rand_poly(poly_in);
            @(negedge clk);
            if (result !== held) stable_ok = 1'b0;
        end
        chk(stable_ok, "R6 result hold", result, held);

        // R5: back-to-back operations, new start in the done cycle
        rand_poly(va);
        rand_poly(vb);
        issue(va);
        wait_done(lat);
        chk(result === ref_mod(va), "R5 first of pair", result, ref_mod(va));
        issue(vb);
        wait_done(lat);
        chk(lat == LATENCY, "R5 back-to-back latency", M'(lat), M'(LATENCY));
        chk(result === ref_mod(vb), "R5 second of pair", result, ref_mod(vb));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule